// File: doc/BRIEF.md
# Three-Component Fixed-Point Vector ALU

This block is the arithmetic unit of a small ray-casting processor. Every operand is a 96-bit row that packs three signed 32-bit fixed-point components, x, y and z, each carrying 17 fraction bits. On each clock it reads a 16-bit opcode and two source rows, A and B. One cycle later it presents the 96-bit result row together with a valid flag.

The operations are component-wise add and subtract and a scaled fixed-point multiply. The vector operations are the dot and cross products and a single-lane product. The single-component operations are increment on one axis or all axes, decrement, negation, lane exchange, fraction and integer split, and scale shifts. A decoder turns the opcode into one operation code for each lane plus a row-level selection. Three generated lane units, a cross-product unit and one output register complete the datapath.

The block is fully pipelined with a fixed latency and has no stall. Any opcode it does not implement returns a zero row with the valid flag low, so the surrounding sequencer can detect it.

Top module: `vec3_alu`

## Requirements
- R1: Component x occupies bits [31:0], y occupies [63:32] and z occupies [95:64]. The result and valid flag reflect the opcode and operands sampled at the previous rising edge. While `rst_n` is low at a rising edge, both the result and the valid flag are cleared to zero.
- R2: Opcode 1 returns A+B and opcode 2 returns A-B. Both act per component and wrap modulo 2^32.
- R3: Opcode 4 multiplies per component. Each lane forms the signed 64-bit product of A and B, shifts it arithmetically right by 17, and keeps the low 32 bits.
- R4: Opcode 14 adds 1.0 (0x20000) to every component of A, and opcode 36 subtracts 1.0 from every component. Opcodes 43, 44 and 45 add 1.0 only to x, y or z respectively and pass the other components of A through.
- R5: Opcode 35 negates every component of A. Opcode 33 keeps only the low 17 bits of each component and clears the rest. Opcode 34 clears the low 17 bits of each component.
- R6: Opcode 41 shifts each component of A arithmetically right by 17. Opcode 42 shifts each component left by 17, discarding the bits shifted out.
- R7: Opcode 23 places the dot product of A and B in all three components. The dot product is the wrapping sum of the three R3 lane products.
- R8: Opcode 22 returns the cross product of A and B. Each term is an R3 fixed-point product, so x = Ay*Bz - Az*By, y = Az*Bx - Ax*Bz and z = Ax*By - Ay*Bx.
- R9: Opcode 31 returns A with z replaced by the R3 fixed-point product Ax*Ay.
- R10: Opcodes 37, 38 and 39 return A with the x, y or z component respectively taken from B.
- R11: Opcode 7 returns A unchanged. Opcode 15 and opcode 0 return an all-zero row. All three assert valid.
- R12: Any other 16-bit opcode value gives an all-zero result with valid low. This includes values that differ from a supported code only in bits 15..7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 16 | Operation code |
| src_a_i | input | 96 | Source row A {z, y, x} |
| src_b_i | input | 96 | Source row B {z, y, x} |
| res_o | output | 96 | Registered result row {z, y, x} |
| res_valid_o | output | 1 | Result corresponds to a supported opcode |

## Verification
The assertions take for granted that the opcode and both source rows are defined at every rising edge once reset is released. Each `|=>` property compares the output with the inputs of the previous edge. The bench meets this condition by driving every input from the falling edge and never leaving one undriven. It also holds the opcode at a known value while reset is low, so that the first cycle after release already compares against valid operands.

// File: rtl/vec3_alu_pkg.sv
// Package: shared opcode values and control encodings for the vector ALU.
// Assumes opcodes are compared on all 16 bits; unlisted values are unsupported.
package vec3_alu_pkg;

    localparam int OP_W = 16;

    localparam logic [OP_W-1:0] OPC_NOP     = 16'd0;
    localparam logic [OP_W-1:0] OPC_ADD     = 16'd1;
    localparam logic [OP_W-1:0] OPC_SUB     = 16'd2;
    localparam logic [OP_W-1:0] OPC_MUL     = 16'd4;
    localparam logic [OP_W-1:0] OPC_COPY    = 16'd7;
    localparam logic [OP_W-1:0] OPC_INC     = 16'd14;
    localparam logic [OP_W-1:0] OPC_ZERO    = 16'd15;
    localparam logic [OP_W-1:0] OPC_CROSS   = 16'd22;
    localparam logic [OP_W-1:0] OPC_DOT     = 16'd23;
    localparam logic [OP_W-1:0] OPC_MULP    = 16'd31;
    localparam logic [OP_W-1:0] OPC_FRAC    = 16'd33;
    localparam logic [OP_W-1:0] OPC_INTP    = 16'd34;
    localparam logic [OP_W-1:0] OPC_NEG     = 16'd35;
    localparam logic [OP_W-1:0] OPC_DEC     = 16'd36;
    localparam logic [OP_W-1:0] OPC_XCHX    = 16'd37;
    localparam logic [OP_W-1:0] OPC_XCHY    = 16'd38;
    localparam logic [OP_W-1:0] OPC_XCHZ    = 16'd39;
    localparam logic [OP_W-1:0] OPC_UNSCALE = 16'd41;
    localparam logic [OP_W-1:0] OPC_RESCALE = 16'd42;
    localparam logic [OP_W-1:0] OPC_INCX    = 16'd43;
    localparam logic [OP_W-1:0] OPC_INCY    = 16'd44;
    localparam logic [OP_W-1:0] OPC_INCZ    = 16'd45;

    // Per-lane operation selected by the decoder.
    typedef enum logic [3:0] {
        LN_PASS, LN_ADD, LN_SUB, LN_MUL, LN_INC, LN_DEC, LN_NEG,
        LN_FRAC, LN_INTP, LN_SHR, LN_SHL, LN_ZERO, LN_TAKE_B
    } lane_op_t;

    // Row-level source of the final result.
    typedef enum logic [1:0] {
        ROW_LANES, ROW_DOT, ROW_CROSS, ROW_MULP
    } row_sel_t;

endpackage

// File: rtl/vec3_decode.sv
// Module: vec3_decode
// Turns a 16-bit opcode into one lane operation per component plus a row
// selection and a supported flag. Purely combinational.
// Assumes three components (x = lane 0, y = lane 1, z = lane 2).
module vec3_decode
    import vec3_alu_pkg::*;
(
    input  logic [OP_W-1:0]    op_i,
    output lane_op_t [2:0]     lane_ops_o,
    output row_sel_t           row_sel_o,
    output logic               supported_o
);

    // Fill every lane with one operation.
    function automatic lane_op_t [2:0] all_lanes(input lane_op_t l);
        return {l, l, l};
    endfunction

    // One lane gets the special op, the others pass A through.
    function automatic lane_op_t [2:0] one_lane(input int idx, input lane_op_t l);
        lane_op_t [2:0] r;
        for (int k = 0; k < 3; k++) begin
            r[k] = (k == idx) ? l : LN_PASS;
        end
        return r;
    endfunction

    // Opcode decode: exact 16-bit match, default is unsupported.
    always_comb begin
        lane_ops_o  = all_lanes(LN_ZERO);
        row_sel_o   = ROW_LANES;
        supported_o = 1'b1;
        case (op_i)
            OPC_NOP:     lane_ops_o = all_lanes(LN_ZERO);
            OPC_ZERO:    lane_ops_o = all_lanes(LN_ZERO);
            OPC_COPY:    lane_ops_o = all_lanes(LN_PASS);
            OPC_ADD:     lane_ops_o = all_lanes(LN_ADD);
            OPC_SUB:     lane_ops_o = all_lanes(LN_SUB);
            OPC_MUL:     lane_ops_o = all_lanes(LN_MUL);
            OPC_INC:     lane_ops_o = all_lanes(LN_INC);
            OPC_DEC:     lane_ops_o = all_lanes(LN_DEC);
            OPC_NEG:     lane_ops_o = all_lanes(LN_NEG);
            OPC_FRAC:    lane_ops_o = all_lanes(LN_FRAC);
            OPC_INTP:    lane_ops_o = all_lanes(LN_INTP);
            OPC_UNSCALE: lane_ops_o = all_lanes(LN_SHR);
            OPC_RESCALE: lane_ops_o = all_lanes(LN_SHL);
            OPC_INCX:    lane_ops_o = one_lane(0, LN_INC);
            OPC_INCY:    lane_ops_o = one_lane(1, LN_INC);
            OPC_INCZ:    lane_ops_o = one_lane(2, LN_INC);
            OPC_XCHX:    lane_ops_o = one_lane(0, LN_TAKE_B);
            OPC_XCHY:    lane_ops_o = one_lane(1, LN_TAKE_B);
            OPC_XCHZ:    lane_ops_o = one_lane(2, LN_TAKE_B);
            OPC_DOT: begin
                lane_ops_o = all_lanes(LN_MUL);
                row_sel_o  = ROW_DOT;
            end
            OPC_CROSS: begin
                lane_ops_o = all_lanes(LN_PASS);
                row_sel_o  = ROW_CROSS;
            end
            OPC_MULP: begin
                lane_ops_o = all_lanes(LN_PASS);
                row_sel_o  = ROW_MULP;
            end
            default:     supported_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/vec3_lane.sv
// Module: vec3_lane
// One component lane: all per-component operations on a W-bit signed
// fixed-point value with F fraction bits. Purely combinational.
// Assumes 0 < F < W.
module vec3_lane
    import vec3_alu_pkg::*;
#(
    parameter int W = 32,
    parameter int F = 17
) (
    input  lane_op_t     lane_op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);

    localparam logic [W-1:0] ONE   = W'(1) << F;
    localparam logic [W-1:0] FMASK = {{(W-F){1'b0}}, {F{1'b1}}};

    logic signed [2*W-1:0] prod;

    // Full-width signed product of the two lane inputs.
    always_comb begin
        prod = $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i});
    end

    // Lane operation select.
    always_comb begin
        case (lane_op_i)
            LN_PASS:   y_o = a_i;
            LN_ADD:    y_o = a_i + b_i;
            LN_SUB:    y_o = a_i - b_i;
            LN_MUL:    y_o = W'(prod >>> F);
            LN_INC:    y_o = a_i + ONE;
            LN_DEC:    y_o = a_i - ONE;
            LN_NEG:    y_o = W'(0) - a_i;
            LN_FRAC:   y_o = a_i & FMASK;
            LN_INTP:   y_o = a_i & ~FMASK;
            LN_SHR:    y_o = W'($signed(a_i) >>> F);
            LN_SHL:    y_o = a_i << F;
            LN_TAKE_B: y_o = b_i;
            default:   y_o = '0;
        endcase
    end

endmodule

// File: rtl/vec3_cross.sv
// Module: vec3_cross
// Cross product of two packed rows and the x*y single-lane product, each
// term a fixed-point multiply (shift right by F, keep W bits).
// Purely combinational; assumes three components, x in the low lane.
module vec3_cross #(
    parameter int W = 32,
    parameter int F = 17
) (
    input  logic [3*W-1:0] a_i,
    input  logic [3*W-1:0] b_i,
    output logic [3*W-1:0] cross_o,
    output logic [W-1:0]   mulp_o
);

    // Fixed-point product truncated to lane width.
    function automatic logic [W-1:0] fxmul(input logic [W-1:0] p, input logic [W-1:0] q);
        logic signed [2*W-1:0] full;
        full = $signed({{W{p[W-1]}}, p}) * $signed({{W{q[W-1]}}, q});
        return W'(full >>> F);
    endfunction

    logic [W-1:0] ax, ay, az, bx, by, bz;

    // Split the rows into named components.
    always_comb begin
        ax = a_i[0*W +: W];
        ay = a_i[1*W +: W];
        az = a_i[2*W +: W];
        bx = b_i[0*W +: W];
        by = b_i[1*W +: W];
        bz = b_i[2*W +: W];
    end

    // Cross product terms and the single-lane product.
    always_comb begin
        cross_o[0*W +: W] = fxmul(ay, bz) - fxmul(az, by);
        cross_o[1*W +: W] = fxmul(az, bx) - fxmul(ax, bz);
        cross_o[2*W +: W] = fxmul(ax, by) - fxmul(ay, bx);
        mulp_o            = fxmul(ax, ay);
    end

endmodule

// File: rtl/vec3_alu.sv
// Module: vec3_alu
// Top of the three-component fixed-point vector ALU. It decodes the opcode,
// runs three generated lanes and the cross unit in parallel, selects the row
// and registers result and valid. Latency is one clock.
// Assumes inputs are defined at every rising edge after reset release.
module vec3_alu
    import vec3_alu_pkg::*;
#(
    parameter int COMP_W = 32,
    parameter int FRAC_W = 17
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [15:0]         op_i,
    input  logic [3*COMP_W-1:0] src_a_i,
    input  logic [3*COMP_W-1:0] src_b_i,
    output logic [3*COMP_W-1:0] res_o,
    output logic                res_valid_o
);

    localparam int NCOMP = 3;
    localparam int ROW_W = NCOMP * COMP_W;

    lane_op_t [2:0]     lane_ops;
    row_sel_t           row_sel;
    logic               supported;
    logic [ROW_W-1:0]   lane_row;
    logic [ROW_W-1:0]   cross_row;
    logic [COMP_W-1:0]  mulp_z;
    logic [COMP_W-1:0]  dot_sum;
    logic [ROW_W-1:0]   next_row;

    vec3_decode dec_i (
        .op_i        (op_i),
        .lane_ops_o  (lane_ops),
        .row_sel_o   (row_sel),
        .supported_o (supported)
    );

    for (genvar g = 0; g < NCOMP; g++) begin : g_lane
        vec3_lane #(.W(COMP_W), .F(FRAC_W)) lane_i (
            .lane_op_i (lane_ops[g]),
            .a_i       (src_a_i[g*COMP_W +: COMP_W]),
            .b_i       (src_b_i[g*COMP_W +: COMP_W]),
            .y_o       (lane_row[g*COMP_W +: COMP_W])
        );
    end

    vec3_cross #(.W(COMP_W), .F(FRAC_W)) cross_i (
        .a_i     (src_a_i),
        .b_i     (src_b_i),
        .cross_o (cross_row),
        .mulp_o  (mulp_z)
    );

    // Dot product reuses the three lane multipliers.
    always_comb begin
        dot_sum = lane_row[0 +: COMP_W] + lane_row[COMP_W +: COMP_W]
                + lane_row[2*COMP_W +: COMP_W];
    end

    // Row selection.
    always_comb begin
        case (row_sel)
            ROW_DOT:   next_row = {dot_sum, dot_sum, dot_sum};
            ROW_CROSS: next_row = cross_row;
            ROW_MULP:  next_row = {mulp_z, lane_row[2*COMP_W-1:0]};
            default:   next_row = lane_row;
        endcase
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o       <= '0;
            res_valid_o <= 1'b0;
        end else begin
            res_o       <= supported ? next_row : '0;
            res_valid_o <= supported;
        end
    end

    AST_INVALID_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> res_o == '0); // R12
    AST_COPY_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OPC_COPY |=> res_valid_o && res_o == $past(src_a_i)); // R11
    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OPC_ZERO |=> res_valid_o && res_o == '0); // R11
    AST_XCHGX_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OPC_XCHX |=> res_o == {$past(src_a_i[ROW_W-1:COMP_W]), $past(src_b_i[COMP_W-1:0])}); // R10
    AST_NEG_SUMS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OPC_NEG |=> res_o[COMP_W-1:0] + $past(src_a_i[COMP_W-1:0]) == '0); // R5
    AST_MULP_KEEPS_XY: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OPC_MULP |=> res_o[2*COMP_W-1:0] == $past(src_a_i[2*COMP_W-1:0])); // R9

endmodule

// File: tb/vec3_alu_tb_top.sv
// Bench for vec3_alu: a vector table walked by one loop against a reference
// model written from the requirements, then directed reset and corner tests.
module vec3_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] op;
    logic [95:0] sa, sb;
    logic [95:0] res;
    logic        res_valid;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    vec3_alu dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op),
        .src_a_i     (sa),
        .src_b_i     (sb),
        .res_o       (res),
        .res_valid_o (res_valid)
    );

    localparam logic [95:0] VA = {32'hFFFA_0000, 32'h0005_0000, 32'h0002_0000};
    localparam logic [95:0] VB = {32'h0001_0000, 32'hFFFD_8000, 32'h0008_0000};
    localparam logic [95:0] VC = {32'h7FFF_FFFF, 32'hFFFE_ABCD, 32'h0003_1234};

    localparam int NV = 24;
    localparam logic [207:0] VECS [NV] = '{
        {16'd1,  VA, VB}, {16'd2,  VA, VB}, {16'd4,  VA, VB}, {16'd14, VA, VB},
        {16'd36, VB, VA}, {16'd43, VA, VB}, {16'd44, VA, VB}, {16'd45, VA, VB},
        {16'd35, VC, VA}, {16'd33, VC, VA}, {16'd34, VC, VA}, {16'd41, VA, VB},
        {16'd42, VC, VB}, {16'd23, VA, VB}, {16'd22, VA, VB}, {16'd31, VA, VB},
        {16'd37, VA, VB}, {16'd38, VA, VB}, {16'd39, VA, VB}, {16'd7,  VC, VB},
        {16'd15, VA, VB}, {16'd0,  VA, VB}, {16'd5,  VA, VB}, {16'd40, VA, VB}
    };

    function automatic logic [31:0] fm(input logic [31:0] p, input logic [31:0] q);
        logic signed [63:0] f;
        f = $signed({{32{p[31]}}, p}) * $signed({{32{q[31]}}, q});
        return f[48:17];
    endfunction

    function automatic string req_of(input logic [15:0] o);
        case (o)
            16'd1, 16'd2:                        return "R2";
            16'd4:                               return "R3";
            16'd14, 16'd36, 16'd43, 16'd44, 16'd45: return "R4";
            16'd33, 16'd34, 16'd35:              return "R5";
            16'd41, 16'd42:                      return "R6";
            16'd23:                              return "R7";
            16'd22:                              return "R8";
            16'd31:                              return "R9";
            16'd37, 16'd38, 16'd39:              return "R10";
            16'd0, 16'd7, 16'd15:                return "R11";
            default:                             return "R12";
        endcase
    endfunction

    // Reference model built from the requirement text.
    task automatic ref_calc(input logic [15:0] o, input logic [95:0] a, input logic [95:0] b,
                            output logic [95:0] r, output logic v);
        logic [31:0] ac [3];
        logic [31:0] bc [3];
        logic [31:0] rc [3];
        logic [31:0] d;
        for (int k = 0; k < 3; k++) begin
            ac[k] = a[k*32 +: 32];
            bc[k] = b[k*32 +: 32];
            rc[k] = ac[k];
        end
        v = 1'b1;
        case (o)
            16'd1:  for (int k = 0; k < 3; k++) rc[k] = ac[k] + bc[k];
            16'd2:  for (int k = 0; k < 3; k++) rc[k] = ac[k] - bc[k];
            16'd4:  for (int k = 0; k < 3; k++) rc[k] = fm(ac[k], bc[k]);
            16'd14: for (int k = 0; k < 3; k++) rc[k] = ac[k] + 32'h2_0000;
            16'd36: for (int k = 0; k < 3; k++) rc[k] = ac[k] - 32'h2_0000;
            16'd43: rc[0] = ac[0] + 32'h2_0000;
            16'd44: rc[1] = ac[1] + 32'h2_0000;
            16'd45: rc[2] = ac[2] + 32'h2_0000;
            16'd35: for (int k = 0; k < 3; k++) rc[k] = -ac[k];
            16'd33: for (int k = 0; k < 3; k++) rc[k] = ac[k] & 32'h0001_FFFF;
            16'd34: for (int k = 0; k < 3; k++) rc[k] = ac[k] & 32'hFFFE_0000;
            16'd41: for (int k = 0; k < 3; k++) rc[k] = 32'($signed(ac[k]) >>> 17);
            16'd42: for (int k = 0; k < 3; k++) rc[k] = ac[k] << 17;
            16'd23: begin
                d = fm(ac[0], bc[0]) + fm(ac[1], bc[1]) + fm(ac[2], bc[2]);
                for (int k = 0; k < 3; k++) rc[k] = d;
            end
            16'd22: begin
                rc[0] = fm(ac[1], bc[2]) - fm(ac[2], bc[1]);
                rc[1] = fm(ac[2], bc[0]) - fm(ac[0], bc[2]);
                rc[2] = fm(ac[0], bc[1]) - fm(ac[1], bc[0]);
            end
            16'd31: rc[2] = fm(ac[0], ac[1]);
            16'd37: rc[0] = bc[0];
            16'd38: rc[1] = bc[1];
            16'd39: rc[2] = bc[2];
            16'd7:  ;
            16'd0, 16'd15: for (int k = 0; k < 3; k++) rc[k] = '0;
            default: begin
                v = 1'b0;
                for (int k = 0; k < 3; k++) rc[k] = '0;
            end
        endcase
        r = {rc[2], rc[1], rc[0]};
    endtask

    task automatic check(input string req, input logic [95:0] exp_r, input logic exp_v);
        n_chk++;
        if (res !== exp_r || res_valid !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual res=%h valid=%b expected res=%h valid=%b",
                     req, res, res_valid, exp_r, exp_v);
        end
    endtask

    // Drive at a falling edge, check at the next falling edge (one register).
    task automatic run_op(input logic [15:0] o, input logic [95:0] a, input logic [95:0] b,
                          input string req, input logic [95:0] exp_r, input logic exp_v);
        @(negedge clk);
        op = o; sa = a; sb = b;
        @(negedge clk);
        check(req, exp_r, exp_v);
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [95:0] er;
        logic        ev;
        rst_n = 1'b0;
        op = 16'd1; sa = VA; sb = VB;
        repeat (3) @(negedge clk);
        check("R1", '0, 1'b0);            // R1 reset clears outputs
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            ref_calc(VECS[i][207:192], VECS[i][191:96], VECS[i][95:0], er, ev);
            run_op(VECS[i][207:192], VECS[i][191:96], VECS[i][95:0],
                   req_of(VECS[i][207:192]), er, ev);
        end

        // R3 hand value: 1.5 * 2.0 = 3.0, -1.0 * 0.5 = -0.5 in every lane pair
        run_op(16'd4, {32'h0003_0000, 32'hFFFE_0000, 32'h0003_0000},
               {32'h0004_0000, 32'h0001_0000, 32'h0004_0000}, "R3",
               {32'h0006_0000, 32'hFFFF_0000, 32'h0006_0000}, 1'b1);
        // R6 hand value: -3.0 >>> 17 = -3
        run_op(16'd41, {32'h0, 32'h0, 32'hFFFA_0000}, VB, "R6",
               {32'h0, 32'h0, 32'hFFFF_FFFD}, 1'b1);
        // R2 wrap: 0x7FFFFFFF + 1 wraps to 0x80000000
        run_op(16'd1, {3{32'h7FFF_FFFF}}, {3{32'h0000_0001}}, "R2",
               {3{32'h8000_0000}}, 1'b1);
        // R12 upper opcode bits set on an otherwise supported code
        run_op(16'h8001, VA, VB, "R12", '0, 1'b0);
        run_op(16'd3, VA, VB, "R12", '0, 1'b0);
        // R7 orthogonal unit vectors give zero dot product
        run_op(16'd23, {32'h0, 32'h0, 32'h2_0000}, {32'h0, 32'h2_0000, 32'h0}, "R7",
               '0, 1'b1);
        // R8 x cross y = z
        run_op(16'd22, {32'h0, 32'h0, 32'h2_0000}, {32'h0, 32'h2_0000, 32'h0}, "R8",
               {32'h2_0000, 32'h0, 32'h0}, 1'b1);

        // R1 back-to-back: second result follows one edge after the first
        @(negedge clk);
        op = 16'd14; sa = VA; sb = VB;
        @(negedge clk);
        op = 16'd7; sa = VC;
        ref_calc(16'd14, VA, VB, er, ev);
        check("R1", er, ev);
        @(negedge clk);
        check("R1", VC, 1'b1);

        // R1 reset in mid-stream clears a pending result
        @(negedge clk);
        op = 16'd1; sa = VA; sb = VB; rst_n = 1'b0;
        @(negedge clk);
        check("R1", '0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule